// File: doc/BRIEF.md
# Freezable channel activity counters

This block measures how busy a radio channel is. It keeps four counters, all in units of the core clock. One advances on every clock. One advances while the receiver reports the medium occupied. One advances while a frame is being received. One advances while a frame is being transmitted. Software derives idle or listen time by dividing the counts by the clock rate.

A single freeze bit in a control register halts all four counters on the same edge. Software therefore sets the freeze bit, reads the four counters, writes zero into each, and then writes zero to the control register to let them run again. Every value it reads comes from one coherent instant. Each counter saturates at all ones instead of wrapping. A sticky flag in the control register records that some counter saturated.

The register port is a plain synchronous read/write port. A read returns data on the clock after the request and changes no state.

Top module: `chan_activity_counters`

## Requirements
- R1: After reset, every counter is zero, and the control register reads zero (freeze bit 0 clear, saturation flag bit 1 clear).
- R2: The total-cycle counter (address 1) advances by one on every clock edge at which the freeze bit is clear, and only on those edges.
- R3: The busy counter (address 2), the receive-frame counter (address 3) and the transmit-frame counter (address 4) each advance by one on a clock edge at which the freeze bit is clear and their level input (`busy_i`, `rxf_i`, `txf_i` in that order) is high.
- R4: While the freeze bit is set, no counter changes except through a register write. Writing the control register with bit 0 set freezes the counters and writing it with bit 0 clear releases them. The new freeze value takes effect from the edge after the write.
- R5: A write to a counter address loads the written value into that counter, so a zero write clears it.
- R6: When a write and an increment fall on the same edge for one counter, the written value wins, and later increments start from that value.
- R7: A counter that holds all ones stays at all ones when it would otherwise advance.
- R8: The saturation flag (control bit 1) is set when any counter is held at all ones by R7. It stays set until a control write with bit 1 set clears it. If a set and a clear fall on the same edge, the set wins.
- R9: A read with `reg_rd_en` high returns, on the following clock, the value the addressed register held at the request edge. Unmapped addresses (5 to 7) read zero, `reg_rdata` holds its value while no read is requested, and reads change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; the unit of every count |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address: 0 control, 1 cycles, 2 busy, 3 rx frame, 4 tx frame |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data, valid the clock after the read strobe |
| busy_i | input | 1 | Medium-busy level from the receiver |
| rxf_i | input | 1 | Frame-receive level |
| txf_i | input | 1 | Frame-transmit level |

## Verification
A counter that misses or adds an edge shows as a wrong snapshot at the next frozen read. The error grows by one count for every edge the freeze logic or an enable is wrong. A freeze bit that takes effect one edge early or late moves every snapshot by exactly one. The bench therefore compares exact totals over windows of known length. A lost write priority shows as the old count plus one instead of the written value plus one. A saturation fault shows within one clock as either a wrapped count near zero or a control word with bit 1 missing.

// File: rtl/chan_act_pkg.sv
package chan_act_pkg;
  localparam int NUM_CNT = 4;
  localparam int ADDR_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_CYC  = 3'd1,
    A_BUSY = 3'd2,
    A_RXF  = 3'd3,
    A_TXF  = 3'd4
  } reg_addr_e;

  localparam int CTRL_FREEZE_BIT = 0;
  localparam int CTRL_OVF_BIT    = 1;

  // counter index k lives at address k+1
  function automatic logic [ADDR_W-1:0] cnt_addr(input int k);
    return ADDR_W'(k + 1);
  endfunction
endpackage

// File: rtl/act_cnt.sv
module act_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_req,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         sat_evt
);
  localparam logic [W-1:0] MAXV = '1;

  function automatic logic [W-1:0] sat_step(input logic [W-1:0] v);
    return (v == MAXV) ? v : v + W'(1);
  endfunction

  logic at_max;
  assign at_max  = (cnt == MAXV);
  assign sat_evt = inc_req && !ld && at_max;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (ld)      cnt <= ld_val;
    else if (inc_req) cnt <= sat_step(cnt);
  end
endmodule

// File: rtl/act_rd_mux.sv
module act_rd_mux
  import chan_act_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [W-1:0]              ctrl_word,
  input  logic [NUM_CNT-1:0][W-1:0] cnt_vec,
  output logic [W-1:0]              rdata
);
  logic [W-1:0] sel;

  always_comb begin
    sel = '0;
    if (addr == A_CTRL) sel = ctrl_word;
    for (int k = 0; k < NUM_CNT; k++)
      if (addr == cnt_addr(k)) sel = cnt_vec[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= sel;
  end
endmodule

// File: rtl/chan_activity_counters.sv
module chan_activity_counters
  import chan_act_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [2:0]        reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic              busy_i,
  input  logic              rxf_i,
  input  logic              txf_i
);
  // named internal events, visible to the checker
  logic                          freeze_q;
  logic                          ovf_q;
  logic                          ctrl_wr;
  logic                          ovf_clr;
  logic [NUM_CNT-1:0]            act_vec;
  logic [NUM_CNT-1:0]            inc_req;
  logic [NUM_CNT-1:0]            ld;
  logic [NUM_CNT-1:0]            sat_evt;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_vec;
  logic [CNT_W-1:0]              ctrl_word;

  assign act_vec = {txf_i, rxf_i, busy_i, 1'b1};
  assign ctrl_wr = reg_wr_en && (reg_addr == A_CTRL);
  assign ovf_clr = ctrl_wr && reg_wdata[CTRL_OVF_BIT];

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    assign inc_req[k] = !freeze_q && act_vec[k];
    assign ld[k]      = reg_wr_en && (reg_addr == cnt_addr(k));
    act_cnt #(.W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_req (inc_req[k]),
      .ld      (ld[k]),
      .ld_val  (reg_wdata),
      .cnt     (cnt_vec[k]),
      .sat_evt (sat_evt[k])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freeze_q <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      if (ctrl_wr) freeze_q <= reg_wdata[CTRL_FREEZE_BIT];
      if (|sat_evt)     ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_FREEZE_BIT] = freeze_q;
    ctrl_word[CTRL_OVF_BIT]    = ovf_q;
  end

  act_rd_mux #(.W(CNT_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (reg_rd_en),
    .addr      (reg_addr),
    .ctrl_word (ctrl_word),
    .cnt_vec   (cnt_vec),
    .rdata     (reg_rdata)
  );
endmodule

// File: rtl/chan_act_chk.sv
module chan_act_chk
  import chan_act_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          freeze_q,
  input logic                          ovf_q,
  input logic                          ovf_clr,
  input logic [NUM_CNT-1:0]            ld,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_vec,
  input logic [CNT_W-1:0]              reg_wdata,
  input logic                          busy_i
);
  localparam logic [CNT_W-1:0] MAXV = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  // R2
  a_r2_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze_q && !ld[0] && cnt_vec[0] != MAXV) |=> cnt_vec[0] == $past(cnt_vec[0]) + ONE);

  // R3
  a_r3_busy_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze_q && busy_i && !ld[1] && cnt_vec[1] != MAXV) |=> cnt_vec[1] == $past(cnt_vec[1]) + ONE);

  a_r3_busy_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && !ld[1]) |=> $stable(cnt_vec[1]));

  // R4
  a_r4_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_q && ld == '0) |=> $stable(cnt_vec));

  // R5, R6
  a_r5_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ld[2] |=> cnt_vec[2] == $past(reg_wdata));

  // R7
  a_r7_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_vec[3] == MAXV && !ld[3]) |=> cnt_vec[3] == MAXV);

  // R8
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);

  a_r8_ovf_on_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze_q && cnt_vec[0] == MAXV && !ld[0]) |=> ovf_q);
endmodule

bind chan_activity_counters chan_act_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .freeze_q  (freeze_q),
  .ovf_q     (ovf_q),
  .ovf_clr   (ovf_clr),
  .ld        (ld),
  .cnt_vec   (cnt_vec),
  .reg_wdata (reg_wdata),
  .busy_i    (busy_i)
);

// File: tb/chan_activity_counters_tb.sv
module chan_activity_counters_tb;
  localparam int W = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic busy = 1'b0, rxf = 1'b0, txf = 1'b0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  chan_activity_counters #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_rd_en(rd_en),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
    .busy_i(busy), .rxf_i(rxf), .txf_i(txf));

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(posedge clk); #1 rd_en = 1'b0; v = rdata;
  endtask

  // frozen, all cleared, then run n cycles of a pattern, then freeze
  task automatic run_window(input int n, input int mode,
                            output int e_b, output int e_r, output int e_t);
    logic [2:0] p;
    wr(3'd0, 1); for (int a = 1; a <= 4; a++) wr(3'(a), 0);
    wr(3'd0, 0);
    e_b = 0; e_r = 0; e_t = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      p = (mode == 0) ? 3'(i) : 3'((i * 5 + i / 3) % 8);
      {txf, rxf, busy} = p;
      e_b += p[0]; e_r += p[1]; e_t += p[2];
      @(posedge clk);
    end
    #1 {txf, rxf, busy} = 3'b000;
    wr(3'd0, 1);
  endtask

  initial begin
    logic [W-1:0] v, v2;
    int eb, er, et;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(3'd0, v); check("R1 ctrl after reset", v, 0);
    wr(3'd0, 1);
    for (int a = 2; a <= 4; a++) begin rd(3'(a), v); check("R1 counter after reset", v, 0); end

    // R2/R3 sweeps over two input patterns and lengths
    for (int m = 0; m < 2; m++) begin
      for (int n = 8; n <= 40; n += 16) begin
        run_window(n, m, eb, er, et);
        rd(3'd1, v); check("R2 cycles", v, W'(n + 1));
        rd(3'd2, v); check("R3 busy", v, W'(eb));
        rd(3'd3, v); check("R3 rx frame", v, W'(er));
        rd(3'd4, v); check("R3 tx frame", v, W'(et));
      end
    end

    // R4 freeze holds all counters while inputs are active
    rd(3'd1, v2);
    #1 {txf, rxf, busy} = 3'b111;
    repeat (10) @(posedge clk);
    #1 {txf, rxf, busy} = 3'b000;
    rd(3'd1, v); check("R4 frozen cycles", v, v2);
    rd(3'd3, v); check("R4 frozen rx frame", v, W'(er));
    rd(3'd0, v); check("R4 ctrl freeze bit", v, 1);

    // R5 load and clear
    wr(3'd4, 32'hA5A5_0001); rd(3'd4, v); check("R5 load", v, 32'hA5A5_0001);
    wr(3'd4, 0);             rd(3'd4, v); check("R5 clear", v, 0);

    // R6 write beats increment
    wr(3'd2, 0); wr(3'd0, 0);
    #1 busy = 1'b1;
    wr(3'd2, 100);
    wr(3'd0, 1);
    #1 busy = 1'b0;
    rd(3'd2, v); check("R6 write priority", v, 101);

    // R7/R8 saturation and sticky flag
    rd(3'd0, v); check("R8 flag clear before", v, 1);
    wr(3'd1, 32'hFFFF_FFFE); wr(3'd0, 0);
    repeat (4) @(posedge clk);
    wr(3'd0, 1);
    rd(3'd1, v); check("R7 saturated", v, 32'hFFFF_FFFF);
    rd(3'd0, v); check("R8 flag set", v, 3);
    wr(3'd0, 1); rd(3'd0, v); check("R8 flag sticky", v, 3);
    wr(3'd0, 3); rd(3'd0, v); check("R8 flag cleared", v, 1);

    // R9 reads: unmapped, repeatable, hold, latency
    rd(3'd6, v); check("R9 unmapped", v, 0);
    rd(3'd2, v); rd(3'd2, v2); check("R9 read no side effect", v2, v);
    repeat (3) @(posedge clk); #1 check("R9 rdata holds", rdata, v);
    @(negedge clk); rd_en = 1'b1; addr = 3'd1;
    #1 check("R9 no early data", rdata, v);
    @(posedge clk); #1 rd_en = 1'b0; check("R9 one cycle latency", rdata, 32'hFFFF_FFFF);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done"); end
    join_any
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule